// File: doc/BRIEF.md
# MDIO Register Write-Verify Controller

This block accepts a 16-bit value for a PHY management register from a host that delivers it as two byte loads. The low byte is loaded first. Loading the high byte launches the operation. The controller sends a clause-22 write frame on the MDIO management bus and then a read frame to the same PHY and register address. It compares the word it reads back with the word it latched. When the two differ, it writes and reads again. It stops when they match, or when a configurable number of retries has been used up.

A three-bit status word tells the host what is happening. Bit 0 is busy, and it stays set for the whole sequence. Bit 1 is a sticky flag for a write that never verified. Bit 2 is a sticky flag for a load that was refused. MDC comes from a simple divider of the system clock. It runs only while a frame is on the wire and rests low at all other times.

Top module: `mdio_wv_ctrl`

## Requirements
- R1: A write frame, sent MSB first with one bit per MDC period, is made of PRE_LEN one bits, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, and then the 16 data bits.
- R2: A read frame carries opcode 10. From the first turnaround bit to the end of the frame, the controller deasserts mdio_oe_o. It shifts in the 16 data bits, MSB first, on the rising edges of MDC.
- R3: A low-byte load stores wbyte_i. A later accepted high-byte load launches a write of {high byte, stored low byte}.
- R4: A high-byte load in the same cycle as a low-byte load, or in the cycle right after one, is ignored. No frame follows it, and it sets status bit 2.
- R5: Status bit 0 (busy) reads 1 in the cycle after an accepted high-byte load. It stays 1 through every frame of the sequence and returns to 0 once the sequence ends.
- R6: Every write frame is followed by a read frame that carries the same PHY and register address.
- R7: If the word read back equals the latched word, the sequence ends. Otherwise the write and the read are issued again.
- R8: If the word still differs after MAX_RETRY retries (MAX_RETRY+1 writes in all), the controller stops, sets sticky status bit 1 and clears busy.
- R9: While busy, low and high loads are both ignored and set status bit 2. The latched word and the stored low byte stay unchanged.
- R10: An accepted high-byte load clears status bits 1 and 2.
- R11: Outside a sequence, MDC stays low and mdio_oe_o stays 0. A bit period lasts 2*CLK_DIV clock cycles.
- R12: After reset, status reads 000, MDC is low and mdio_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_lo_i | input | 1 | Load strobe for the low data byte |
| wr_hi_i | input | 1 | Load strobe for the high data byte; launches the operation |
| wbyte_i | input | 8 | Byte that goes with either load strobe |
| phy_addr_i | input | 5 | PHY address, captured on launch |
| reg_addr_i | input | 5 | Register address, captured on launch |
| status_o | output | 3 | {load refused, verify failed, busy} |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the controller with CLK_DIV=2, MAX_RETRY=2 and PRE_LEN=32. The two-cycle divider keeps each 64-bit frame to 256 clock cycles, so a full sequence of three writes and three reads fits well inside the run. With a retry limit of 2, a modelled PHY that corrupts three writes in a row is enough to exhaust the retries and set the failure flag. A PHY that corrupts only one write shows a single successful retry.

// File: rtl/mdio_wv_pkg.sv
package mdio_wv_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WR,
    SEQ_RD,
    SEQ_CHK
  } seq_state_e;

  localparam logic [1:0] START_BITS = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] TA_WRITE   = 2'b10;
endpackage

// File: rtl/mdio_wv_clkdiv.sv
module mdio_wv_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic mdc_o,
  output logic rise_o,
  output logic end_o
);
  localparam int PH_W = (2 * DIV > 1) ? $clog2(2 * DIV) : 1;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * DIV - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(DIV);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else if (!en_i || ph_q == PH_LAST) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign mdc_o  = ph_q >= PH_HIGH;
  assign rise_o = en_i && (ph_q == PH_RISE);
  assign end_o  = en_i && (ph_q == PH_LAST);

  AST_MDC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !mdc_o); // R11
endmodule

// File: rtl/mdio_wv_frame.sv
module mdio_wv_frame
  import mdio_wv_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV     = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        mdio_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        active_o,
  output logic        done_o,
  output logic [15:0] rd_data_o
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] TA_POS   = CNT_W'(PRE_LEN + 14);
  localparam logic [CNT_W-1:0] DATA_POS = CNT_W'(PRE_LEN + 16);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  logic                 active_q;
  logic                 rd_q;
  logic                 done_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [FRAME_LEN-1:0] frame_q;
  logic [15:0]          rsh_q;
  logic                 bit_rise;
  logic                 bit_end;
  logic [FRAME_LEN-1:0] frame_init;

  mdio_wv_clkdiv #(.DIV(DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (active_q),
    .mdc_o  (mdc_o),
    .rise_o (bit_rise),
    .end_o  (bit_end)
  );

  always_comb begin
    frame_init = {{PRE_LEN{1'b1}}, START_BITS, (rd_i ? OP_READ : OP_WRITE),
                  phy_i, reg_i, (rd_i ? 2'b00 : TA_WRITE),
                  (rd_i ? 16'h0000 : wdata_i)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      frame_q  <= '0;
      rsh_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          rd_q     <= rd_i;
          cnt_q    <= '0;
          frame_q  <= frame_init;
        end
      end else begin
        // read data is taken on the edge where mdc goes high
        if (bit_rise && rd_q && cnt_q >= DATA_POS) begin
          rsh_q <= {rsh_q[14:0], mdio_i};
        end
        if (bit_end) begin
          frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
          if (cnt_q == LAST_POS) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
            cnt_q    <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign mdio_oe_o = active_q && !(rd_q && cnt_q >= TA_POS);
  assign mdio_o    = mdio_oe_o && frame_q[FRAME_LEN-1];
  assign active_o  = active_q;
  assign done_o    = done_q;
  assign rd_data_o = rsh_q;

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q); // R6
endmodule

// File: rtl/mdio_wv_host.sv
module mdio_wv_host (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [7:0]  byte_i,
  input  logic        busy_i,
  output logic        launch_o,
  output logic [15:0] word_o,
  output logic        ignore_o
);
  logic [7:0] lo_byte_q;
  logic       lo_seen_q;
  logic       lo_ok;
  logic       hi_ok;

  assign lo_ok = wr_lo_i && !busy_i;
  // high load needs one idle cycle after the low load
  assign hi_ok = wr_hi_i && !busy_i && !wr_lo_i && !lo_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_byte_q <= '0;
      lo_seen_q <= 1'b0;
    end else begin
      lo_seen_q <= lo_ok;
      if (lo_ok) lo_byte_q <= byte_i;
    end
  end

  assign launch_o = hi_ok;
  assign word_o   = {byte_i, lo_byte_q};
  assign ignore_o = (wr_lo_i && busy_i) || (wr_hi_i && !hi_ok);

  AST_LO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(lo_byte_q)); // R9
endmodule

// File: rtl/mdio_wv_seq.sv
module mdio_wv_seq
  import mdio_wv_pkg::*;
#(
  parameter int MAX_RETRY = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        launch_i,
  input  logic [15:0] word_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic        ignore_i,
  input  logic        eng_done_i,
  input  logic [15:0] eng_rdata_i,
  output logic        start_o,
  output logic        rd_o,
  output logic [15:0] wdata_o,
  output logic [4:0]  phy_o,
  output logic [4:0]  reg_o,
  output logic [2:0]  status_o
);
  localparam int RET_W = $clog2(MAX_RETRY + 2);
  localparam logic [RET_W-1:0] RET_MAX = RET_W'(MAX_RETRY);

  seq_state_e       state_q;
  logic             start_q;
  logic             rd_q;
  logic [RET_W-1:0] retry_q;
  logic [15:0]      wdata_q;
  logic [4:0]       phy_q;
  logic [4:0]       reg_q;
  logic             fail_q;
  logic             ign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      start_q <= 1'b0;
      rd_q    <= 1'b0;
      retry_q <= '0;
      wdata_q <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      fail_q  <= 1'b0;
      ign_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (ignore_i) ign_q <= 1'b1;
      unique case (state_q)
        SEQ_IDLE: begin
          if (launch_i) begin
            state_q <= SEQ_WR;
            start_q <= 1'b1;
            rd_q    <= 1'b0;
            retry_q <= '0;
            wdata_q <= word_i;
            phy_q   <= phy_i;
            reg_q   <= reg_i;
            fail_q  <= 1'b0;
            ign_q   <= 1'b0;
          end
        end
        SEQ_WR: begin
          if (eng_done_i) begin
            state_q <= SEQ_RD;
            start_q <= 1'b1;
            rd_q    <= 1'b1;
          end
        end
        SEQ_RD: begin
          if (eng_done_i) state_q <= SEQ_CHK;
        end
        SEQ_CHK: begin
          if (eng_rdata_i == wdata_q) begin
            state_q <= SEQ_IDLE;
          end else if (retry_q == RET_MAX) begin
            fail_q  <= 1'b1;
            state_q <= SEQ_IDLE;
          end else begin
            retry_q <= retry_q + 1'b1;
            state_q <= SEQ_WR;
            start_q <= 1'b1;
            rd_q    <= 1'b0;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign start_o  = start_q;
  assign rd_o     = rd_q;
  assign wdata_o  = wdata_q;
  assign phy_o    = phy_q;
  assign reg_o    = reg_q;
  assign status_o = {ign_q, fail_q, (state_q != SEQ_IDLE)};

  AST_RETRY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_q <= RET_MAX); // R8
  AST_FAIL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> state_q == SEQ_IDLE); // R8
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != SEQ_IDLE |=> $stable(wdata_q)); // R9
endmodule

// File: rtl/mdio_wv_ctrl.sv
module mdio_wv_ctrl #(
  parameter int CLK_DIV   = 4,
  parameter int MAX_RETRY = 3,
  parameter int PRE_LEN   = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_lo_i,
  input  logic       wr_hi_i,
  input  logic [7:0] wbyte_i,
  input  logic [4:0] phy_addr_i,
  input  logic [4:0] reg_addr_i,
  output logic [2:0] status_o,
  output logic       mdc_o,
  output logic       mdio_o,
  output logic       mdio_oe_o,
  input  logic       mdio_i
);
  logic        launch;
  logic [15:0] word;
  logic        ignore;
  logic        eng_start;
  logic        eng_rd;
  logic [15:0] eng_wdata;
  logic [4:0]  eng_phy;
  logic [4:0]  eng_reg;
  logic        eng_active;
  logic        eng_done;
  logic [15:0] eng_rdata;
  logic [2:0]  status;

  mdio_wv_host u_host (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_lo_i  (wr_lo_i),
    .wr_hi_i  (wr_hi_i),
    .byte_i   (wbyte_i),
    .busy_i   (status[0]),
    .launch_o (launch),
    .word_o   (word),
    .ignore_o (ignore)
  );

  mdio_wv_seq #(.MAX_RETRY(MAX_RETRY)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .word_i      (word),
    .phy_i       (phy_addr_i),
    .reg_i       (reg_addr_i),
    .ignore_i    (ignore),
    .eng_done_i  (eng_done),
    .eng_rdata_i (eng_rdata),
    .start_o     (eng_start),
    .rd_o        (eng_rd),
    .wdata_o     (eng_wdata),
    .phy_o       (eng_phy),
    .reg_o       (eng_reg),
    .status_o    (status)
  );

  mdio_wv_frame #(.PRE_LEN(PRE_LEN), .DIV(CLK_DIV)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start),
    .rd_i      (eng_rd),
    .phy_i     (eng_phy),
    .reg_i     (eng_reg),
    .wdata_i   (eng_wdata),
    .mdio_i    (mdio_i),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .active_o  (eng_active),
    .done_o    (eng_done),
    .rd_data_o (eng_rdata)
  );

  assign status_o = status;

  AST_BUSY_MDC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o || eng_active) |-> status[0]); // R5
endmodule

// File: tb/tb_mdio_wv_ctrl.sv
module tb_mdio_wv_ctrl;
  localparam int PRE  = 32;
  localparam int FL   = PRE + 32;
  localparam int TA   = PRE + 14;
  localparam int DATA = PRE + 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_lo = 1'b0;
  logic       wr_hi = 1'b0;
  logic [7:0] wbyte = 8'h00;
  logic [4:0] phy_a = 5'h0B;
  logic [4:0] reg_a = 5'h11;
  logic [2:0] status;
  logic       mdc;
  logic       mdio_o;
  logic       oe;
  logic       mdio_in = 1'b1;

  int checks = 0;
  int failures = 0;

  // bench PHY model state
  logic [15:0] phy_regs [32];
  logic [63:0] fbits = '0;
  int  pos = 0;
  logic cur_rd = 1'b0;
  logic [4:0] cur_reg = '0;
  logic prev_mdc = 1'b0;
  int  wr_frames = 0;
  int  rd_frames = 0;
  int  corrupt_left = 0;
  int  oe_err = 0;
  int  clk_err = 0;
  logic [15:0] exp_data = '0;
  logic [4:0]  exp_phy = 5'h0B;
  logic [4:0]  exp_reg = 5'h11;

  always #5 clk = ~clk;

  mdio_wv_ctrl #(.CLK_DIV(2), .MAX_RETRY(2), .PRE_LEN(PRE)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_lo_i    (wr_lo),
    .wr_hi_i    (wr_hi),
    .wbyte_i    (wbyte),
    .phy_addr_i (phy_a),
    .reg_addr_i (reg_a),
    .status_o   (status),
    .mdc_o      (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (oe),
    .mdio_i     (mdio_in)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic frame_done();
    chk(fbits[63:32] == 32'hFFFF_FFFF, "R1 preamble", int'(fbits[63:32]), 32'hFFFF_FFFF);
    chk(fbits[31:30] == 2'b01, "R1 start bits", int'(fbits[31:30]), 1);
    chk(fbits[27:23] == exp_phy, "R6 phy address", int'(fbits[27:23]), int'(exp_phy));
    chk(fbits[22:18] == exp_reg, "R6 reg address", int'(fbits[22:18]), int'(exp_reg));
    if (fbits[29:28] == 2'b01) begin
      wr_frames++;
      chk(fbits[17:16] == 2'b10, "R1 write turnaround", int'(fbits[17:16]), 2);
      chk(fbits[15:0] == exp_data, "R1 R9 write data", int'(fbits[15:0]), int'(exp_data));
      if (corrupt_left > 0) begin
        phy_regs[fbits[22:18]] = fbits[15:0] ^ 16'h005A;
        corrupt_left--;
      end else begin
        phy_regs[fbits[22:18]] = fbits[15:0];
      end
    end else begin
      rd_frames++;
      chk(fbits[29:28] == 2'b10, "R2 read opcode", int'(fbits[29:28]), 2);
      chk(wr_frames == rd_frames, "R6 read follows write", rd_frames, wr_frames);
    end
  endtask

  // PHY model and per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      pos = 0;
      prev_mdc = 1'b0;
      cur_rd = 1'b0;
    end else begin
      if (mdc && !prev_mdc) begin
        if (oe !== !(cur_rd && pos >= TA)) oe_err++;
        fbits = {fbits[62:0], mdio_o};
        if (pos == PRE + 3) cur_rd = (fbits[1:0] == 2'b10);
        if (pos == PRE + 13) cur_reg = fbits[4:0];
        if (pos == FL - 1) begin
          frame_done();
          pos = 0;
          cur_rd = 1'b0;
        end else begin
          pos++;
        end
      end
      if (!mdc && prev_mdc) begin
        if (cur_rd && pos == TA + 1) mdio_in = 1'b0;
        else if (cur_rd && pos >= DATA) mdio_in = phy_regs[cur_reg][15 - (pos - DATA)];
        else mdio_in = 1'b1;
      end
      if (mdc && !status[0]) clk_err++;
      if (!status[0] && (mdc || oe)) clk_err++;
      prev_mdc = mdc;
    end
  end

  task automatic pulse_lo(input logic [7:0] b);
    wbyte = b;
    wr_lo = 1'b1;
    @(negedge clk);
    wr_lo = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_hi(input logic [7:0] b);
    wbyte = b;
    wr_hi = 1'b1;
    @(negedge clk);
    wr_hi = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (status[0] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic reset_counts();
    wr_frames = 0;
    rd_frames = 0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(status == 3'b000, "R12 status in reset", int'(status), 0);
    chk(mdc == 1'b0 && oe == 1'b0, "R12 bus idle in reset", int'({mdc, oe}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(status == 3'b000, "R12 status after reset", int'(status), 0);

    // clean write, verified first time
    reset_counts();
    exp_data = 16'hA53C;
    pulse_lo(8'h3C);
    pulse_hi(8'hA5);
    chk(status[0] == 1'b1, "R5 busy after launch", int'(status[0]), 1);
    repeat (2) @(negedge clk);
    chk(status[0] == 1'b1, "R5 busy two cycles on", int'(status[0]), 1);
    wait_idle();
    chk(wr_frames == 1 && rd_frames == 1, "R3 R7 single write and read", wr_frames * 16 + rd_frames, 16'h11);
    chk(status == 3'b000, "R5 idle after match", int'(status), 0);
    chk(phy_regs[5'h11] == 16'hA53C, "R3 PHY holds value", int'(phy_regs[5'h11]), 16'hA53C);

    // one corrupted write, one retry
    reset_counts();
    corrupt_left = 1;
    exp_data = 16'h1234;
    pulse_lo(8'h34);
    pulse_hi(8'h12);
    wait_idle();
    chk(wr_frames == 2 && rd_frames == 2, "R7 retry after mismatch", wr_frames * 16 + rd_frames, 16'h22);
    chk(status == 3'b000, "R7 success after retry", int'(status), 0);
    chk(phy_regs[5'h11] == 16'h1234, "R7 PHY value after retry", int'(phy_regs[5'h11]), 16'h1234);

    // retries exhausted, with refused loads while busy
    reset_counts();
    corrupt_left = 3;
    exp_data = 16'hBEEF;
    pulse_lo(8'hEF);
    pulse_hi(8'hBE);
    repeat (20) @(negedge clk);
    pulse_lo(8'h77);
    pulse_hi(8'h99);
    @(negedge clk);
    chk(status == 3'b101, "R9 refused load flagged while busy", int'(status), 5);
    wait_idle();
    chk(wr_frames == 3 && rd_frames == 3, "R8 writes before giving up", wr_frames * 16 + rd_frames, 16'h33);
    chk(status == 3'b110, "R8 fail sticky and busy clear", int'(status), 6);

    // next launch keeps the old low byte and clears the flags
    reset_counts();
    corrupt_left = 0;
    reg_a = 5'h04;
    exp_reg = 5'h04;
    exp_data = 16'h5AEF;
    pulse_hi(8'h5A);
    chk(status == 3'b001, "R10 flags cleared on launch", int'(status), 1);
    wait_idle();
    chk(wr_frames == 1 && rd_frames == 1, "R9 low byte kept across refused load", wr_frames * 16 + rd_frames, 16'h11);
    chk(phy_regs[5'h04] == 16'h5AEF, "R9 R3 combined word", int'(phy_regs[5'h04]), 16'h5AEF);

    // high load directly after low load is refused
    reset_counts();
    wbyte = 8'h66;
    wr_lo = 1'b1;
    @(negedge clk);
    wr_lo = 1'b0;
    wbyte = 8'h44;
    wr_hi = 1'b1;
    @(negedge clk);
    wr_hi = 1'b0;
    @(negedge clk);
    chk(status == 3'b100, "R4 early high load refused", int'(status), 4);
    repeat (40) @(negedge clk);
    chk(wr_frames == 0 && rd_frames == 0, "R4 no frame after refused load", wr_frames + rd_frames, 0);
    exp_data = 16'h4466;
    pulse_hi(8'h44);
    chk(status == 3'b001, "R3 R10 launch after gap", int'(status), 1);
    wait_idle();
    chk(phy_regs[5'h04] == 16'h4466, "R3 word from staged bytes", int'(phy_regs[5'h04]), 16'h4466);

    chk(oe_err == 0, "R2 drive enable per bit", oe_err, 0);
    chk(clk_err == 0, "R11 bus idle outside sequence", clk_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R5 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule